// File: doc/BRIEF.md
# Four-Channel Prescaled PWM Generator with Boundary-Synchronised Updates

The block holds four independent pulse-width channels behind a small word-addressed register bus. Each channel has its own register group: a prescaler, a period length counted in steps, a high-time counted in steps, and an enable bit. A channel's step counter advances once every prescale+1 clocks. The output is high for the first high-time steps of each period.

Software stages new values in the prescale and period registers. Writing the high-time register arms an update. The armed values are loaded at the end of the period that is running, so no period is ever produced from a mix of old and new settings. An update armed while the channel is off is loaded when the channel is next switched on. Clearing the enable bit stops the channel at once. The output drops low, and the prescaler and step counter return to zero. All registers read back the value last written, cut to the width of their field.

Top module: `pwm_bank`

## Requirements
- R1: The byte address selects the channel with bits [6:5] and the register with bits [4:0]. The register offsets are 0x00 for prescale (8 bits), 0x04 for period length (8 bits), 0x08 for high-time (16 bits) and 0x18 for enable (bit 0). A read returns the last value written, masked to the field width, with all upper bits zero. Any other offset reads as zero and ignores writes.
- R2: When a channel is running with active values P, M and D, its output in the t-th clock after it starts is high exactly when ((t / (P+1)) mod M) < D. Sample t=0 is the second clock edge after the edge that writes enable=1.
- R3: If D >= M, the output stays high for the whole period. If D = 0, the output stays low. If M = 0, the output stays low.
- R4: A write to the prescale register or the period register on its own does not change the output.
- R5: A write to the high-time register arms the staged prescale, period and high-time values. They become active at the next period boundary. If the write edge is the boundary edge itself, the new values apply from that boundary.
- R6: Writing 0 to enable forces the output low from the write edge onward. Enabling again starts a fresh period at step 0 with the active values.
- R7: An update armed while the channel is disabled becomes active when the channel is next enabled. The first period after enabling already uses the new values.
- R8: Register writes and outputs of one channel do not affect any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one clock |
| bus_addr | input | 7 | Byte address: channel and register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | 4 | One waveform output per channel |

## Verification
Two events can fall in the same clock: a write to the high-time register and the period boundary it is waiting for. The bench places that write so that its edge is exactly the boundary edge. It then expects the new waveform from that boundary onward, not one full period later. A second collision is an armed update meeting the enable edge. This is provoked by staging a full configuration while the channel is off and then enabling it. The first period is judged against the new values.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

  localparam int PRE_W  = 8;
  localparam int MOD_W  = 8;
  localparam int DUTY_W = 16;
  localparam int OFS_W  = 5;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_PRE,
    RK_MOD,
    RK_DUTY,
    RK_EN
  } reg_kind_e;

  // Register selected by the offset inside a channel window
  function automatic reg_kind_e decode_off(input logic [OFS_W-1:0] off);
    case (off)
      5'h00:   return RK_PRE;
      5'h04:   return RK_MOD;
      5'h08:   return RK_DUTY;
      5'h18:   return RK_EN;
      default: return RK_NONE;
    endcase
  endfunction

  // Output level for a step of a period
  function automatic logic wave_level(input logic [MOD_W-1:0]  step,
                                      input logic [MOD_W-1:0]  modv,
                                      input logic [DUTY_W-1:0] dutyv);
    return (modv != '0) && (DUTY_W'(step) < dutyv);
  endfunction

  // Last step of a period; a zero length ends at every step
  function automatic logic is_last_step(input logic [MOD_W-1:0] step,
                                        input logic [MOD_W-1:0] modv);
    return (modv == '0) || (step == modv - MOD_W'(1));
  endfunction

endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_wr,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [DATA_W-1:0]             bus_wdata,
  output logic [DATA_W-1:0]             bus_rdata,
  output logic [NUM_CH-1:0][PRE_W-1:0]  pre_nxt,
  output logic [NUM_CH-1:0][MOD_W-1:0]  mod_nxt,
  output logic [NUM_CH-1:0][DUTY_W-1:0] duty_nxt,
  output logic [NUM_CH-1:0]             chan_en,
  output logic [NUM_CH-1:0]             commit
);

  localparam int SEL_W = ADDR_W - OFS_W;

  logic [SEL_W-1:0] sel;
  logic [OFS_W-1:0] off;
  reg_kind_e        kind;

  assign sel  = bus_addr[ADDR_W-1:OFS_W];
  assign off  = bus_addr[OFS_W-1:0];
  assign kind = decode_off(off);

  logic [NUM_CH-1:0][PRE_W-1:0]  pre_v;
  logic [NUM_CH-1:0][MOD_W-1:0]  mod_v;
  logic [NUM_CH-1:0][DUTY_W-1:0] duty_v;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic              hit;
    logic              w_pre, w_mod, w_duty, w_en;
    logic [PRE_W-1:0]  pre_q;
    logic [MOD_W-1:0]  mod_q;
    logic [DUTY_W-1:0] duty_q;
    logic              en_q;

    assign hit    = bus_wr && (sel == SEL_W'(c));
    assign w_pre  = hit && (kind == RK_PRE);
    assign w_mod  = hit && (kind == RK_MOD);
    assign w_duty = hit && (kind == RK_DUTY);
    assign w_en   = hit && (kind == RK_EN);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pre_q  <= '0;
        mod_q  <= '0;
        duty_q <= '0;
        en_q   <= 1'b0;
      end else begin
        if (w_pre)  pre_q  <= bus_wdata[PRE_W-1:0];
        if (w_mod)  mod_q  <= bus_wdata[MOD_W-1:0];
        if (w_duty) duty_q <= bus_wdata[DUTY_W-1:0];
        if (w_en)   en_q   <= bus_wdata[0];
      end
    end

    // Staged values as they stand after this clock, forwarded for a same-cycle commit
    assign pre_nxt[c]  = w_pre  ? bus_wdata[PRE_W-1:0]  : pre_q;
    assign mod_nxt[c]  = w_mod  ? bus_wdata[MOD_W-1:0]  : mod_q;
    assign duty_nxt[c] = w_duty ? bus_wdata[DUTY_W-1:0] : duty_q;
    assign commit[c]   = w_duty;
    assign chan_en[c]  = en_q;
    assign pre_v[c]    = pre_q;
    assign mod_v[c]    = mod_q;
    assign duty_v[c]   = duty_q;
  end

  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (sel == SEL_W'(c)) begin
        case (kind)
          RK_PRE:  bus_rdata = DATA_W'(pre_v[c]);
          RK_MOD:  bus_rdata = DATA_W'(mod_v[c]);
          RK_DUTY: bus_rdata = DATA_W'(duty_v[c]);
          RK_EN:   bus_rdata = DATA_W'(chan_en[c]);
          default: bus_rdata = '0;
        endcase
      end
    end
  end

  AST_ONE_CH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(commit)); // R8

endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
  import pwm_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              commit,
  input  logic [PRE_W-1:0]  pre_nxt,
  input  logic [MOD_W-1:0]  mod_nxt,
  input  logic [DUTY_W-1:0] duty_nxt,
  output logic              out
);

  logic              run;
  logic              pend;
  logic [PRE_W-1:0]  pre_cnt;
  logic [MOD_W-1:0]  step;
  logic [PRE_W-1:0]  act_pre;
  logic [MOD_W-1:0]  act_mod;
  logic [DUTY_W-1:0] act_duty;

  // Named internal events
  logic tick;
  logic bnd;
  logic start;
  logic apply;

  assign tick  = run && (pre_cnt == act_pre);
  assign bnd   = tick && is_last_step(step, act_mod);
  assign start = en && !run;
  assign apply = en && (start || bnd) && (pend || commit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run      <= 1'b0;
      pend     <= 1'b0;
      pre_cnt  <= '0;
      step     <= '0;
      act_pre  <= '0;
      act_mod  <= '0;
      act_duty <= '0;
    end else begin
      pend <= (pend || commit) && !apply;
      if (apply) begin
        act_pre  <= pre_nxt;
        act_mod  <= mod_nxt;
        act_duty <= duty_nxt;
      end
      if (!en) begin
        run     <= 1'b0;
        pre_cnt <= '0;
        step    <= '0;
      end else if (!run) begin
        run     <= 1'b1;
        pre_cnt <= '0;
        step    <= '0;
      end else if (tick) begin
        pre_cnt <= '0;
        step    <= bnd ? '0 : step + MOD_W'(1);
      end else begin
        pre_cnt <= pre_cnt + PRE_W'(1);
      end
    end
  end

  assign out = en && run && wave_level(step, act_mod, act_duty);

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !bnd) |=> ($stable(act_pre) && $stable(act_mod) && $stable(act_duty))); // R5
  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (run && act_mod != '0) |-> (step < act_mod)); // R2
  AST_PEND_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (en && run && bnd) |=> !pend); // R5
  AST_STOP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!run && step == '0 && pre_cnt == '0)); // R6
  AST_ARM_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (pend || commit)) |=> !pend); // R7

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);

  logic [NUM_CH-1:0][PRE_W-1:0]  pre_nxt;
  logic [NUM_CH-1:0][MOD_W-1:0]  mod_nxt;
  logic [NUM_CH-1:0][DUTY_W-1:0] duty_nxt;
  logic [NUM_CH-1:0]             chan_en;
  logic [NUM_CH-1:0]             commit;

  pwm_bank_regs #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pre_nxt   (pre_nxt),
    .mod_nxt   (mod_nxt),
    .duty_nxt  (duty_nxt),
    .chan_en   (chan_en),
    .commit    (commit)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    pwm_bank_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (chan_en[c]),
      .commit   (commit[c]),
      .pre_nxt  (pre_nxt[c]),
      .mod_nxt  (mod_nxt[c]),
      .duty_nxt (duty_nxt[c]),
      .out      (pwm_out[c])
    );
  end

  AST_OFF_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(chan_en) == '0 && chan_en == '0) |-> (pwm_out == '0)); // R6

endmodule

// File: tb/pwm_bank_bench.sv
module pwm_bank_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_bank u_pwm_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out)
  );

  localparam int O_PRE = 'h00, O_MOD = 'h04, O_DUTY = 'h08, O_EN = 'h18;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit ref_lvl(input int t, input int p, input int m, input int d);
    if (m == 0) return 1'b0;
    return ((t / (p + 1)) % m) < d;
  endfunction

  task automatic wr(input int ch, input int off, input int data);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 7'(ch * 32 + off); bus_wdata = 32'(data);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input int ch, input int off, input int exp);
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 7'(ch * 32 + off);
    #1;
    chk(bus_rdata == 32'(exp), "R1", int'(bus_rdata), exp);
  endtask

  // kind 0: commit at boundary, kind 1: no change, kind 2: stop
  task automatic watch(input int ch, input int n, input int ci, input int woff,
                       input int wdata, input int kind,
                       input int op, input int om, input int od,
                       input int np, input int nm, input int nd,
                       input bit iso, input string tag);
    int lold, kl;
    bit e;
    lold = (om == 0) ? (op + 1) : om * (op + 1);
    kl = ((ci + lold) / lold) * lold;
    for (int t = 0; t < n; t++) begin
      @(negedge clk);
      if (kind == 0)      e = (t < kl) ? ref_lvl(t, op, om, od) : ref_lvl(t - kl, np, nm, nd);
      else if (kind == 2) e = (t <= ci) ? ref_lvl(t, op, om, od) : 1'b0;
      else                e = ref_lvl(t, op, om, od);
      chk(pwm_out[ch] == e, tag, int'(pwm_out[ch]), int'(e));
      if (iso) chk((pwm_out & ~(4'b1 << ch)) == 4'b0, "R8", int'(pwm_out), 0);
      if (t == ci) begin
        bus_wr = 1'b1; bus_addr = 7'(ch * 32 + woff); bus_wdata = 32'(wdata);
      end else begin
        bus_wr = 1'b0;
      end
    end
    bus_wr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pwm_out == 4'b0, "R6 reset", int'(pwm_out), 0);
    rd_chk(0, O_DUTY, 0);
    rd_chk(2, O_EN, 0);

    // R1 register map, masking and unmapped offsets
    wr(3, O_PRE, 'h1AB);
    wr(3, O_MOD, 'h3FF);
    wr(3, O_DUTY, 'h12345);
    wr(3, 'h0C, 'h55);
    wr(3, O_EN, 3);
    rd_chk(3, O_PRE, 'hAB);
    rd_chk(3, O_MOD, 'hFF);
    rd_chk(3, O_DUTY, 'h2345);
    rd_chk(3, O_EN, 1);
    rd_chk(3, 'h0C, 0);
    rd_chk(3, 'h10, 0);
    rd_chk(1, O_PRE, 0);   // R8 other channel untouched
    wr(3, O_EN, 0);
    rd_chk(3, O_EN, 0);
    @(negedge clk);
    chk(pwm_out == 4'b0, "R6", int'(pwm_out), 0);

    // R2 R3 R7: sweep with the whole configuration staged while disabled
    begin
      int idx;
      int mset[5];
      int dset[5];
      mset = '{0, 1, 2, 3, 5};
      dset = '{0, 1, 2, 3, 6};
      idx = 0;
      for (int p = 0; p < 3; p++) begin
        for (int mi = 0; mi < 5; mi++) begin
          for (int di = 0; di < 5; di++) begin
            int ch;
            int l;
            ch = idx % 4;
            l = (mset[mi] == 0) ? 4 : mset[mi] * (p + 1);
            wr(ch, O_PRE, p);
            wr(ch, O_MOD, mset[mi]);
            wr(ch, O_DUTY, dset[di]);
            wr(ch, O_EN, 1);
            watch(ch, 2 * l + 3, -1, 0, 0, 1, p, mset[mi], dset[di], 0, 0, 0, 1'b1, "R2 R3 R7");
            wr(ch, O_EN, 0);
            idx++;
          end
        end
      end
    end

    // R5: commit mid-period, applied at the boundary (t=8)
    wr(0, O_PRE, 1); wr(0, O_MOD, 4); wr(0, O_DUTY, 1);
    wr(0, O_EN, 1);
    watch(0, 24, 2, O_DUTY, 3, 0, 1, 4, 1, 1, 4, 3, 1'b1, "R5");

    // R4 R6: fresh period after re-enable; period write alone has no effect
    wr(0, O_EN, 0); wr(0, O_EN, 1);
    watch(0, 20, 3, O_MOD, 2, 1, 1, 4, 3, 0, 0, 0, 1'b1, "R4");
    wr(0, O_EN, 0); wr(0, O_EN, 1);
    watch(0, 20, 2, O_PRE, 0, 1, 1, 4, 3, 0, 0, 0, 1'b1, "R4");

    // R5: commit edge coincides with boundary edge; staged pre=0 mod=2 duty=1
    wr(0, O_EN, 0); wr(0, O_EN, 1);
    watch(0, 24, 7, O_DUTY, 1, 0, 1, 4, 3, 0, 2, 1, 1'b1, "R5 same-cycle");

    // R6: immediate stop mid-period
    wr(0, O_EN, 0); wr(0, O_EN, 1);
    watch(0, 12, 0, O_EN, 0, 2, 0, 2, 1, 0, 0, 0, 1'b1, "R6");
    wr(0, O_PRE, 2); wr(0, O_MOD, 3); wr(0, O_DUTY, 2);
    wr(0, O_EN, 1);
    watch(0, 24, -1, 0, 0, 1, 2, 3, 2, 0, 0, 0, 1'b1, "R7");
    wr(0, O_EN, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule